// File: doc/BRIEF.md
# Windowed Power-Good Supervisor

This block watches a sampled output-voltage code against a target-voltage code and reports whether the supply is in regulation. The voltage counts as good only when it lies inside an inclusive band from 93 % to 107 % of the target. The enable input must also be high.

Power-good rises only after the supply has stayed good for a long qualification time, nominally 1.3 ms. Once it is high, it falls only after the supply has been bad for a short deglitch time, nominally 33 µs. A bad sample during qualification restarts the wait, so brief transients never release the flag early. A return to good during the deglitch window cancels the pending drop.

The flag is also delivered as a pull-down enable for an open-drain pin, whose high level comes from an external pull-up. Both delays are converted from microseconds to clock cycles at elaboration, using the clock frequency parameter in kHz.

Top module: `pg_supervisor`

## Requirements
- R1: A sample is in the window when `target*93/100` rounded up ≤ `vout` ≤ `target*107/100` rounded down, so both limits are inclusive and the window is never wider than the exact percentages.
- R2: With Q = CLK_KHZ*QUAL_US/1000 (integer, Q ≥ 2), `pg_o` goes high on the clock edge that samples the Q-th consecutive good sample. A good sample is one that is in the window with `en_i` high.
- R3: A bad sample while `pg_o` is low discards all good samples collected so far, and qualification restarts from zero.
- R4: With D = CLK_KHZ*DGL_US/1000 (integer, D ≥ 2), `pg_o` goes low on the edge that samples the D-th consecutive bad sample.
- R5: A run of fewer than D bad samples followed by a good one leaves `pg_o` high, and the next excursion again needs D full bad samples.
- R6: `en_i` low makes a sample bad, using the same D-sample deglitch path as a window fault. `pg_o` never rises while `en_i` is low.
- R7: `pd_o` is always the inverse of `pg_o` (1 = pull the open-drain pin low).
- R8: While `arst_ni` is low, `pg_o` is 0, `pd_o` is 1 and both counts are cleared. The reset release is synchronized over two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| arst_ni | input | 1 | Asynchronous active-low reset |
| vout_code_i | input | CODE_W | Sampled output-voltage code |
| target_code_i | input | CODE_W | Target-voltage code |
| en_i | input | 1 | Converter enable |
| pg_o | output | 1 | Power-good flag |
| pd_o | output | 1 | Pull-down enable for the open-drain pin |

## Verification
The bench builds the block with CLK_KHZ = 200 and the other parameters at their defaults. This gives a 260-cycle qualification and a 6-cycle deglitch. With these values, rises, restarts after a single bad sample, and excursions of 5 versus 6 samples can all be exercised directly. Targets of 1000 and 1001 place the inclusive and inward-rounded limits at 929/930, 1070/1071 and 930/931, so each limit is tested one code either side.

// File: rtl/pg_supervisor_pkg.sv
package pg_supervisor_pkg;

  typedef enum logic [1:0] {
    PG_IDLE = 2'd0,  // flag low, waiting for a good sample
    PG_QUAL = 2'd1,  // flag low, counting good samples
    PG_HOLD = 2'd2,  // flag high, supply good
    PG_DROP = 2'd3   // flag high, counting bad samples
  } pg_state_e;

  function automatic int unsigned us_to_cycles(input int unsigned clk_khz,
                                               input int unsigned dur_us);
    return (clk_khz * dur_us) / 1000;
  endfunction

endpackage

// File: rtl/pg_window_cmp.sv
module pg_window_cmp #(
  parameter int unsigned CODE_W = 12,
  parameter int unsigned LO_PCT = 93,
  parameter int unsigned HI_PCT = 107
) (
  input  logic [CODE_W-1:0] vout_i,
  input  logic [CODE_W-1:0] target_i,
  output logic              in_win_o
);
  // Cross-multiplied compare: v*100 >= t*LO and v*100 <= t*HI is exactly
  // ceil/floor inward rounding of the limits without a divider.
  localparam int unsigned PW = CODE_W + 8;

  logic [PW-1:0] v_scaled;
  logic [PW-1:0] lo_scaled;
  logic [PW-1:0] hi_scaled;

  always_comb begin
    v_scaled  = PW'(vout_i)   * PW'(100);
    lo_scaled = PW'(target_i) * PW'(LO_PCT);
    hi_scaled = PW'(target_i) * PW'(HI_PCT);
    in_win_o  = (v_scaled >= lo_scaled) && (v_scaled <= hi_scaled);
  end

endmodule

// File: rtl/pg_run_counter.sv
module pg_run_counter #(
  parameter int unsigned LIMIT = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_one_i,
  input  logic step_i,
  input  logic clear_i,
  output logic last_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST_VAL = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clear_i || load_one_i || step_i;
    cnt_d  = cnt_q;
    if (clear_i)         cnt_d = '0;
    else if (load_one_i) cnt_d = CW'(1);
    else if (step_i)     cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last_o = (cnt_q == LAST_VAL);

  // R2
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST_VAL);

  // R8
  clear_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_q == '0));

endmodule

// File: rtl/pg_supervisor.sv
module pg_supervisor
  import pg_supervisor_pkg::*;
#(
  parameter int unsigned CODE_W  = 12,
  parameter int unsigned CLK_KHZ = 10000,
  parameter int unsigned QUAL_US = 1300,
  parameter int unsigned DGL_US  = 33,
  parameter int unsigned LO_PCT  = 93,
  parameter int unsigned HI_PCT  = 107
) (
  input  logic              clk_i,
  input  logic              arst_ni,
  input  logic [CODE_W-1:0] vout_code_i,
  input  logic [CODE_W-1:0] target_code_i,
  input  logic              en_i,
  output logic              pg_o,
  output logic              pd_o
);
  localparam int unsigned QUAL_CYC = us_to_cycles(CLK_KHZ, QUAL_US);
  localparam int unsigned DGL_CYC  = us_to_cycles(CLK_KHZ, DGL_US);

  // reset: asserted asynchronously, released after two edges
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) rst_sync_q <= 2'b00;
    else          rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic in_win;
  logic ok;

  pg_window_cmp #(
    .CODE_W (CODE_W),
    .LO_PCT (LO_PCT),
    .HI_PCT (HI_PCT)
  ) win_i (
    .vout_i   (vout_code_i),
    .target_i (target_code_i),
    .in_win_o (in_win)
  );

  assign ok = in_win && en_i;

  pg_state_e state_q;
  pg_state_e state_d;
  logic qual_load, qual_step, qual_clr, qual_last;
  logic dgl_load,  dgl_step,  dgl_clr,  dgl_last;

  pg_run_counter #(.LIMIT(QUAL_CYC)) qual_cnt_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .load_one_i (qual_load),
    .step_i     (qual_step),
    .clear_i    (qual_clr),
    .last_o     (qual_last)
  );

  pg_run_counter #(.LIMIT(DGL_CYC)) dgl_cnt_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .load_one_i (dgl_load),
    .step_i     (dgl_step),
    .clear_i    (dgl_clr),
    .last_o     (dgl_last)
  );

  always_comb begin
    state_d   = state_q;
    qual_load = 1'b0;
    qual_step = 1'b0;
    qual_clr  = 1'b0;
    dgl_load  = 1'b0;
    dgl_step  = 1'b0;
    dgl_clr   = 1'b0;
    unique case (state_q)
      PG_IDLE: begin
        if (ok) begin
          state_d   = PG_QUAL;
          qual_load = 1'b1;
        end
      end
      PG_QUAL: begin
        if (!ok) begin
          state_d  = PG_IDLE;
          qual_clr = 1'b1;
        end else if (qual_last) begin
          state_d  = PG_HOLD;
          qual_clr = 1'b1;
        end else begin
          qual_step = 1'b1;
        end
      end
      PG_HOLD: begin
        if (!ok) begin
          state_d  = PG_DROP;
          dgl_load = 1'b1;
        end
      end
      PG_DROP: begin
        if (ok) begin
          state_d = PG_HOLD;
          dgl_clr = 1'b1;
        end else if (dgl_last) begin
          state_d = PG_IDLE;
          dgl_clr = 1'b1;
        end else begin
          dgl_step = 1'b1;
        end
      end
      default: state_d = PG_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) state_q <= PG_IDLE;
    else        state_q <= state_d;
  end

  assign pg_o = (state_q == PG_HOLD) || (state_q == PG_DROP);
  assign pd_o = ~pg_o;

  // R2
  rise_after_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(pg_o) |-> $past(ok));

  // R4
  fall_after_bad_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $fell(pg_o) |-> !$past(ok));

  // R5
  hold_while_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (pg_o && ok) |=> pg_o);

  // R6
  no_rise_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!pg_o && !en_i) |=> !pg_o);

  // R3
  restart_on_bad_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!pg_o && !ok) |=> (state_q == PG_IDLE));

endmodule

// File: tb/pg_supervisor_tb.sv
module pg_supervisor_tb_top;
  localparam int CLK_PER = 10;
  localparam int CODE_W  = 12;
  localparam int CLK_KHZ = 200;
  localparam int Q       = CLK_KHZ * 1300 / 1000;  // 260
  localparam int D       = CLK_KHZ * 33 / 1000;    // 6

  logic clk = 1'b0;
  logic arst_n;
  logic [CODE_W-1:0] vout, tgt;
  logic en;
  logic pg, pd;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  bit    exp_q[$];
  string tag_q[$];

  bit mpg  = 1'b0;
  int qrun = 0;
  int drun = 0;

  always #(CLK_PER/2) clk = ~clk;

  pg_supervisor #(.CODE_W(CODE_W), .CLK_KHZ(CLK_KHZ)) dut_i (
    .clk_i(clk), .arst_ni(arst_n), .vout_code_i(vout),
    .target_code_i(tgt), .en_i(en), .pg_o(pg), .pd_o(pd)
  );

  task automatic check(input string tag, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // R1 reference: inward-rounded integer limits
  function automatic bit in_window(input int v, input int t);
    int lo, hi;
    lo = (t * 93 + 99) / 100;
    hi = (t * 107) / 100;
    return (v >= lo) && (v <= hi);
  endfunction

  // driver: apply one sample, push expected flag after the next edge
  task automatic drive(input int v, input int t, input bit e, input string tag);
    bit ok;
    @(negedge clk);
    vout = CODE_W'(v);
    tgt  = CODE_W'(t);
    en   = e;
    ok   = e && in_window(v, t);
    if (!mpg) begin
      if (ok) begin
        qrun++;
        if (qrun == Q) begin mpg = 1'b1; qrun = 0; end
      end else qrun = 0;
    end else begin
      if (!ok) begin
        drun++;
        if (drun == D) begin mpg = 1'b0; drun = 0; end
      end else drun = 0;
    end
    exp_q.push_back(mpg);
    tag_q.push_back(tag);
  endtask

  task automatic run(input int n, input int v, input int t, input bit e,
                     input string tag);
    for (int i = 0; i < n; i++) drive(v, t, e, tag);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: compare each cycle shortly after the edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PER/4);
      if (exp_q.size() != 0) begin
        bit    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " pg"}, pg, e);
        check("R7 pd", pd, !pg);
      end
    end
  end

  initial begin
    #(CLK_PER * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    arst_n = 1'b0; vout = '0; tgt = '0; en = 1'b0;
    #(CLK_PER * 3);
    check("R8 reset pg", pg, 1'b0);
    check("R8 reset pd", pd, 1'b1);
    @(negedge clk); arst_n = 1'b1;
    run(4, 1000, 1000, 1'b0, "R8 sync");

    // R6: good voltage, enable low: never rises
    run(Q + 20, 1000, 1000, 1'b0, "R6 no rise disabled");
    // R2: rise at the Q-th good sample
    run(Q + 5, 1000, 1000, 1'b1, "R2 rise");
    // R5: short excursion, then second short one
    run(D - 1, 1200, 1000, 1'b1, "R5 short high");
    run(3, 1000, 1000, 1'b1, "R5 back");
    run(D - 1, 500, 1000, 1'b1, "R5 short low");
    run(3, 1000, 1000, 1'b1, "R5 back2");
    // R4: full excursion drops
    run(D + 3, 1200, 1000, 1'b1, "R4 drop");
    // R3: restart on single bad sample
    run(Q - 10, 1000, 1000, 1'b1, "R3 partial");
    drive(1300, 1000, 1'b1, "R3 bad");
    run(Q - 5, 1000, 1000, 1'b1, "R3 no early rise");
    run(10, 1000, 1000, 1'b1, "R3 rise after restart");
    // R6: enable low deglitch
    run(D - 1, 1000, 1000, 1'b0, "R6 short en low");
    run(2, 1000, 1000, 1'b1, "R6 en back");
    run(D + 2, 1000, 1000, 1'b0, "R6 en drop");
    // R1 limits, target 1000: 930 and 1070 good, 929 and 1071 bad
    run(Q + 2, 930, 1000, 1'b1, "R1 lo edge in");
    run(D + 1, 929, 1000, 1'b1, "R1 lo edge out");
    run(Q + 2, 1070, 1000, 1'b1, "R1 hi edge in");
    run(D + 1, 1071, 1000, 1'b1, "R1 hi edge out");
    // R1 rounding, target 1001: 930 bad, 931 and 1071 good, 1072 bad
    run(Q + 5, 930, 1001, 1'b1, "R1 round lo out");
    run(Q + 2, 931, 1001, 1'b1, "R1 round lo in");
    run(4, 1071, 1001, 1'b1, "R1 round hi in");
    run(D + 1, 1072, 1001, 1'b1, "R1 round hi out");
    // R8: reset while good
    run(Q + 2, 1000, 1000, 1'b1, "R8 pre");
    drain();
    arst_n = 1'b0;
    #1;
    check("R8 async pg", pg, 1'b0);
    check("R8 async pd", pd, 1'b1);
    @(negedge clk); arst_n = 1'b1;
    mpg = 1'b0; qrun = 0; drun = 0;
    run(4, 1000, 1000, 1'b0, "R8 resync");
    run(Q + 2, 1000, 1000, 1'b1, "R8 requalify");
    drain();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule